// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block turns one switching request into two gate commands for a half-bridge, one for the upper switch and one for the lower switch. The two commands never overlap. Each turn-on waits out its own dead time: the upper gate counts from the moment the lower gate command has gone low, and the lower gate counts from the moment the upper control logic drops its command. The two dead times are separate parameters in clock cycles. At a 100 MHz reference clock, 25 and 30 cycles give 250 ns and 300 ns.

Supply supervision arrives as digital flags. Until the driver rail first reports good, both gates stay off and no fault is raised. After that, losing the rail forces both gates off and raises the fault output. When the rail returns, the fault clears and switching resumes.

A separate bootstrap flag guards the upper side. If the bootstrap is low when the request rises, the upper gate is held off. The hold ends as soon as the bootstrap is good while the switch node reads high. Otherwise it ends only when the request goes low and then rises again with the bootstrap good. An externally latched short-circuit flag keeps both gates off and the fault high for as long as it is asserted.

Top module: `hb_gate_seq`

## Requirements
- R1: While `rst` is high, and in the first sample after it, `hs_gate_o`, `ls_gate_o` and `fault_o` are all 0.
- R2: `hs_gate_o` and `ls_gate_o` are never 1 in the same cycle.
- R3: `hs_gate_o` rises only after `ls_gate_o` has been 0 for at least HS_DEAD+1 consecutive cycles. With the upper side requested steadily and nothing blocking it, `hs_gate_o` rises HS_DEAD+2 clock edges after `in_i` goes from 0 to 1 while `ls_gate_o` was 1.
- R4: `ls_gate_o` rises only after `hs_gate_o` has been 0 for at least LS_DEAD+1 consecutive cycles. With the lower side requested steadily, `ls_gate_o` rises LS_DEAD+2 clock edges after `in_i` goes from 1 to 0 while `hs_gate_o` was 1.
- R5: When `en_i` is 0, both gates are 0 one edge later. With `en_i` at 1, `in_i`=1 selects the upper gate and `in_i`=0 selects the lower gate.
- R6: Before `vdd_ok_i` has first been 1 after reset, both gates are 0 and `fault_o` is 0.
- R7: Once `vdd_ok_i` has been 1, a cycle with `vdd_ok_i`=0 gives `fault_o`=1 and both gates 0 one edge later. When `vdd_ok_i` returns to 1, `fault_o` goes back to 0 one edge later and the gates follow `in_i` again.
- R8: While `short_i` is 1, both gates are 0 and `fault_o` is 1, each one edge after the input.
- R9: A 0-to-1 change of `in_i` seen while `boot_ok_i` is 0 holds `hs_gate_o` at 0.
- R10: The hold of R9 ends in any cycle where `boot_ok_i` and `sw_hi_i` are both 1.
- R11: With `sw_hi_i` at 0, the hold of R9 stays in force after `boot_ok_i` recovers. It ends only when `in_i` goes to 0 and then rises again while `boot_ok_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; 0 forces both gates off |
| in_i | input | 1 | Switching request; 1 = upper side, 0 = lower side |
| vdd_ok_i | input | 1 | Driver rail good flag |
| boot_ok_i | input | 1 | Bootstrap rail good flag |
| sw_hi_i | input | 1 | Digitised switch-node level, 1 = high |
| short_i | input | 1 | Latched short-circuit flag from an external monitor |
| hs_gate_o | output | 1 | Upper-switch gate command |
| ls_gate_o | output | 1 | Lower-switch gate command |
| fault_o | output | 1 | Fault indication |

## Verification
The bench builds the block with HS_DEAD=5 and LS_DEAD=8 rather than the nanosecond-scale defaults. Dead-time windows of a few cycles let thousands of random cycles cross many full commutations, and they bring both the exact-latency checks and the minimum-gap checks within a short run. Because the two values differ, a swap of the two dead times also shows up. Directed phases drive the bootstrap hold into both release paths, the rail drop and recovery, the short-circuit flag and the pre-power state.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef enum logic [1:0] {
    SIDE_NONE = 2'd0,
    SIDE_HS   = 2'd1,
    SIDE_LS   = 2'd2
  } side_e;

endpackage

// File: rtl/hb_dead_timer.sv
module hb_dead_timer #(
  parameter int DEAD = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic opp_on_i,
  output logic ready_o
);
  localparam int CW = (DEAD < 1) ? 1 : $clog2(DEAD + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (opp_on_i) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = (cnt_q == LIMIT);

  p_ready_needs_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    opp_on_i |=> !ready_o);

endmodule

// File: rtl/hb_lockout.sv
module hb_lockout (
  input  logic clk,
  input  logic rst,
  input  logic vdd_ok_i,
  input  logic boot_ok_i,
  input  logic sw_hi_i,
  input  logic in_i,
  input  logic short_i,
  output logic powered_o,
  output logic hs_block_o,
  output logic fault_o
);
  logic powered_q, in_q, block_q, fault_q, block_d, in_rise;

  assign in_rise = in_i && !in_q;

  always_comb begin
    block_d = block_q;
    if (in_rise) begin
      block_d = !boot_ok_i;
    end else if (block_q && boot_ok_i && sw_hi_i) begin
      block_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      powered_q <= 1'b0;
      in_q      <= 1'b0;
      block_q   <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      powered_q <= powered_q || vdd_ok_i;
      in_q      <= in_i;
      block_q   <= block_d;
      fault_q   <= short_i || (powered_q && !vdd_ok_i);
    end
  end

  assign powered_o  = powered_q;
  assign hs_block_o = block_d;
  assign fault_o    = fault_q;

  p_block_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (block_q && !sw_hi_i && !in_rise) |-> hs_block_o);

  p_prepower_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!powered_q && !short_i) |=> !fault_o);

endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int HS_DEAD = 25,
  parameter int LS_DEAD = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic in_i,
  input  logic vdd_ok_i,
  input  logic boot_ok_i,
  input  logic sw_hi_i,
  input  logic short_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic fault_o
);
  import hb_pkg::*;

  logic        powered, hs_block, run;
  logic        hs_q, ls_q;
  logic [1:0]  ready;
  logic [1:0]  opp_on;
  side_e       sel;

  hb_lockout u_lockout (
    .clk        (clk),
    .rst        (rst),
    .vdd_ok_i   (vdd_ok_i),
    .boot_ok_i  (boot_ok_i),
    .sw_hi_i    (sw_hi_i),
    .in_i       (in_i),
    .short_i    (short_i),
    .powered_o  (powered),
    .hs_block_o (hs_block),
    .fault_o    (fault_o)
  );

  // index 0: upper side (waits on lower gate), index 1: lower side (waits on upper gate)
  assign opp_on = {hs_q, ls_q};

  for (genvar s = 0; s < 2; s++) begin : g_dead
    hb_dead_timer #(.DEAD(s == 0 ? HS_DEAD : LS_DEAD)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .opp_on_i (opp_on[s]),
      .ready_o  (ready[s])
    );
  end

  assign run = en_i && vdd_ok_i && !short_i;

  always_comb begin
    sel = SIDE_NONE;
    if (run) begin
      if (!in_i)          sel = SIDE_LS;
      else if (!hs_block) sel = SIDE_HS;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      hs_q <= (sel == SIDE_HS) && ready[0] && !ls_q;
      ls_q <= (sel == SIDE_LS) && ready[1] && !hs_q;
    end
  end

  assign hs_gate_o = hs_q;
  assign ls_gate_o = ls_q;

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate_o && ls_gate_o));

  p_hs_gap_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate_o) |-> ($past(!ls_gate_o) && !ls_gate_o));

  p_ls_gap_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate_o) |-> ($past(!hs_gate_o) && !hs_gate_o));

  p_enable_off_r5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!hs_gate_o && !ls_gate_o));

  p_supply_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (powered && !vdd_ok_i) |=> (!hs_gate_o && !ls_gate_o && fault_o));

  p_short_off_r8: assert property (@(posedge clk) disable iff (rst)
    short_i |=> (!hs_gate_o && !ls_gate_o && fault_o));

  p_boot_hold_r9: assert property (@(posedge clk) disable iff (rst)
    hs_block |=> !hs_gate_o);

endmodule

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
  localparam int HS_D = 5;
  localparam int LS_D = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic en_i = 0, in_i = 0, vdd_ok_i = 0, boot_ok_i = 0, sw_hi_i = 0, short_i = 0;
  logic hs_gate_o, ls_gate_o, fault_o;
  int   n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  hb_gate_seq #(.HS_DEAD(HS_D), .LS_DEAD(LS_D)) i_hb_gate_seq (
    .clk(clk), .rst(rst), .en_i(en_i), .in_i(in_i), .vdd_ok_i(vdd_ok_i),
    .boot_ok_i(boot_ok_i), .sw_hi_i(sw_hi_i), .short_i(short_i),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o), .fault_o(fault_o)
  );

  // reference model built from the requirements
  logic m_g1 = 0, m_g2 = 0, m_flt = 0, m_pwr = 0, m_inq = 0, m_blk = 0;
  int   m_ch = 0, m_cl = 0;

  function automatic logic blk_next(logic blk, logic inq, logic in_v, logic boot, logic sw);
    if (in_v && !inq) return !boot;
    if (blk && boot && sw) return 1'b0;
    return blk;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_g1 = 0; m_g2 = 0; m_flt = 0; m_pwr = 0; m_inq = 0; m_blk = 0; m_ch = 0; m_cl = 0;
    end else begin
      logic b, run, ng1, ng2;
      b    = blk_next(m_blk, m_inq, in_i, boot_ok_i, sw_hi_i);
      run  = en_i && vdd_ok_i && !short_i;
      ng1  = run && in_i && !b && (m_ch == HS_D) && !m_g2;
      ng2  = run && !in_i && (m_cl == LS_D) && !m_g1;
      m_ch = m_g2 ? 0 : ((m_ch < HS_D) ? m_ch + 1 : m_ch);
      m_cl = m_g1 ? 0 : ((m_cl < LS_D) ? m_cl + 1 : m_cl);
      m_flt = short_i || (m_pwr && !vdd_ok_i);
      m_pwr = m_pwr || vdd_ok_i;
      m_inq = in_i;
      m_blk = b;
      m_g1 = ng1;
      m_g2 = ng2;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // gap tracking at the ports
  int  low_g2 = 0, low_g1 = 0;
  logic p_g1 = 0, p_g2 = 0;

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    chk({hs_gate_o, ls_gate_o, fault_o} == {m_g1, m_g2, m_flt}, req,
        {hs_gate_o, ls_gate_o, fault_o}, {m_g1, m_g2, m_flt});
    if (hs_gate_o && ls_gate_o) chk(1'b0, "R2 overlap", 1, 0);
    if (hs_gate_o && !p_g1) chk(low_g2 >= HS_D + 1, "R3 gap", low_g2, HS_D + 1);
    if (ls_gate_o && !p_g2) chk(low_g1 >= LS_D + 1, "R4 gap", low_g1, LS_D + 1);
    low_g2 = ls_gate_o ? 0 : low_g2 + 1;
    low_g1 = hs_gate_o ? 0 : low_g1 + 1;
    p_g1 = hs_gate_o;
    p_g2 = ls_gate_o;
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  // counts edges until the given gate rises; returns limit+1 if never
  task automatic wait_rise(input logic hs, input int limit, output int n);
    n = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      tick(hs ? "R3" : "R4");
      if ((hs ? hs_gate_o : ls_gate_o) == 1'b1) begin
        n = i;
        break;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    @(negedge clk);
    ticks(4, "R1 reset");
    chk({hs_gate_o, ls_gate_o, fault_o} == 3'b000, "R1", {hs_gate_o, ls_gate_o, fault_o}, 0);
    rst = 0; en_i = 1; in_i = 1; boot_ok_i = 1;
    tick("R1 first");
    ticks(6, "R6 prepower");
    chk({hs_gate_o, ls_gate_o, fault_o} == 3'b000, "R6", {hs_gate_o, ls_gate_o, fault_o}, 0);

    // power up on lower side, then commute
    in_i = 0; vdd_ok_i = 1;
    ticks(12, "R5 lower");
    chk(ls_gate_o == 1'b1, "R5 lower side", ls_gate_o, 1);
    in_i = 1;
    wait_rise(1'b1, 40, n);
    chk(n == HS_D + 2, "R3 latency", n, HS_D + 2);
    ticks(3, "R5 upper");
    in_i = 0;
    wait_rise(1'b0, 40, n);
    chk(n == LS_D + 2, "R4 latency", n, LS_D + 2);

    // enable low
    en_i = 0;
    tick("R5 disable");
    chk(!hs_gate_o && !ls_gate_o, "R5 disable", {hs_gate_o, ls_gate_o}, 0);
    en_i = 1;
    ticks(12, "R5 reenable");

    // rail drop and recovery
    vdd_ok_i = 0;
    tick("R7 drop");
    chk(fault_o && !ls_gate_o, "R7 drop", {fault_o, ls_gate_o}, 2);
    ticks(3, "R7 hold");
    vdd_ok_i = 1;
    tick("R7 clear");
    chk(!fault_o, "R7 clear", fault_o, 0);
    ticks(12, "R7 resume");
    chk(ls_gate_o, "R7 resume", ls_gate_o, 1);

    // short circuit
    short_i = 1;
    tick("R8 short");
    chk(fault_o && !ls_gate_o, "R8 short", {fault_o, ls_gate_o}, 2);
    ticks(5, "R8 hold");
    short_i = 0;
    ticks(12, "R8 release");

    // bootstrap hold, switch node low: needs a fresh rising request
    boot_ok_i = 0; sw_hi_i = 0; in_i = 1;
    ticks(20, "R9 hold");
    chk(!hs_gate_o, "R9 hold", hs_gate_o, 0);
    boot_ok_i = 1;
    ticks(20, "R11 still held");
    chk(!hs_gate_o, "R11 still held", hs_gate_o, 0);
    in_i = 0; tick("R11 toggle"); in_i = 1;
    wait_rise(1'b1, 40, n);
    chk(n <= 40, "R11 rearm", n, HS_D + 2);

    // bootstrap hold, switch node high: release on recovery
    in_i = 0; ticks(15, "R10 setup");
    boot_ok_i = 0; in_i = 1;
    ticks(10, "R9 hold2");
    sw_hi_i = 1;
    ticks(5, "R10 sw high, boot low");
    chk(!hs_gate_o, "R10 still blocked", hs_gate_o, 0);
    boot_ok_i = 1;
    wait_rise(1'b1, 40, n);
    chk(n <= 2, "R10 release", n, 2);
    sw_hi_i = 0;

    // constrained random
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(19) == 0) in_i = ~in_i;
      en_i      = ($urandom_range(99) < 95);
      vdd_ok_i  = ($urandom_range(99) < 97);
      short_i   = ($urandom_range(99) < 2);
      boot_ok_i = ($urandom_range(99) < 85);
      sw_hi_i   = $urandom_range(1);
      tick("R2-random model");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule